// File: doc/BRIEF.md
# Closed-Page DRAM Bank Scheduler

This block sequences the commands for a single DRAM bank under a strict closed-page policy. It takes one read or write request at a time. For each request it opens the row, performs the single column access, and closes the row again. Between commands it waits out parameterized timing counts. Refresh and self-refresh take the bank out of service for timed intervals, and accesses are held off while they run.

The bank contains a small word-addressed store, so a read returns exactly the data last written to the same address. A controller drives the request valid/ready pair and receives one response pulse per accepted request. It can also raise a refresh request at any time, and it requests entry to and exit from self-refresh. The command issued in each cycle is visible on `cmd_o`, so timing can be observed at the boundary.

Top module: `dram_bank_sched`

## Requirements
- R1: Every accepted request produces ACT (code 1) in the accept cycle, then exactly one RD (code 2) or WR (code 3), then PRE (code 4) in the cycle right after the column command. All other cycles of the access show NOP (code 0).
- R2: The RD/WR command appears exactly T_RCD cycles after its ACT.
- R3: After a PRE, no ACT, REF (code 5) or SRE (code 6) is issued for T_RP cycles. The bank is ready again exactly T_RP cycles after the PRE.
- R4: A REF keeps the bank busy: the next command and `req_ready_o` come exactly T_RFC cycles after the REF.
- R5: A refresh request is only served from idle. A refresh request raised during an access is remembered. REF is then issued in the cycle the access's tRP ends, ahead of any waiting request.
- R6: SRE is issued from idle while `sr_enter_i` is high. No request is accepted until `sr_exit_i` produces SRX (code 7). The bank is ready exactly T_XS cycles after SRX.
- R7: Refresh requests raised during self-refresh or its exit delay are dropped. No REF follows the exit.
- R8: A write stores its data at the addressed word. A later read of that address returns the most recent data written there.
- R9: `req_ready_o` is high only in idle. Each accepted request gives exactly one `resp_valid_o` pulse, T_RCD+1+T_RP cycles after acceptance. `resp_write_o` is set for a write and clear for a read.
- R10: After reset the bank is idle: ready high, no response, NOP on `cmd_o`.
- R11: In idle, a refresh takes priority over self-refresh entry, and self-refresh entry takes priority over a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Bank idle and accepting |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_write_o | output | 1 | Completed request was a write |
| resp_rdata_o | output | DATA_W | Read data of the last read |
| ref_req_i | input | 1 | Refresh request pulse |
| sr_enter_i | input | 1 | Request self-refresh entry (hold until SRE) |
| sr_exit_i | input | 1 | Request self-refresh exit |
| cmd_o | output | 3 | Command issued this cycle |

## Verification
The hardest case to reach is a refresh request that arrives while a row is open and another request is already waiting. In that case the remembered refresh must win over the waiting request in the very cycle the precharge time ends. The bench pulses the refresh input one cycle after an ACT and keeps the next request valid through the response cycle. It then checks that REF, not ACT, appears there, and that ACT follows exactly tRFC later. Self-refresh is entered with a request and a refresh pulse both pending. This shows that neither leaks through the exit.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_SRE = 3'd6,
    CMD_SRX = 3'd7
  } bank_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT_WAIT,
    ST_ACCESS,
    ST_PRE,
    ST_PRE_WAIT,
    ST_REF_WAIT,
    ST_SELF_REF,
    ST_SRX_WAIT
  } bank_state_e;

endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end

endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
  import dram_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 2,
  parameter int T_RFC  = 6,
  parameter int T_XS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic              resp_write_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  input  logic              ref_req_i,
  input  logic              sr_enter_i,
  input  logic              sr_exit_i,
  output logic [2:0]        cmd_o
);

  localparam int T_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_B   = (T_RFC > T_XS) ? T_RFC : T_XS;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1);

  bank_state_e       state_q, state_d;
  bank_cmd_e         cmd;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              ref_pend_q, ref_any, ref_clr;
  logic              resp_q, resp_wr_q, resp_set;
  logic              accept, ready;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              store_we, store_re;

  assign ref_any = ref_pend_q | ref_req_i;

  always_comb begin
    state_d  = state_q;
    cmd      = CMD_NOP;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ready    = 1'b0;
    accept   = 1'b0;
    store_we = 1'b0;
    store_re = 1'b0;
    ref_clr  = 1'b0;
    resp_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_any) begin
          cmd      = CMD_REF;
          ref_clr  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RFC - 2);
          state_d  = ST_REF_WAIT;
        end else if (sr_enter_i) begin
          cmd     = CMD_SRE;
          state_d = ST_SELF_REF;
        end else begin
          ready = 1'b1;
          if (req_valid_i) begin
            accept   = 1'b1;
            cmd      = CMD_ACT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RCD - 2);
            state_d  = ST_ACT_WAIT;
          end
        end
      end
      ST_ACT_WAIT: if (tmr_done) state_d = ST_ACCESS;
      ST_ACCESS: begin
        cmd      = wr_q ? CMD_WR : CMD_RD;
        store_we = wr_q;
        store_re = !wr_q;
        state_d  = ST_PRE;
      end
      ST_PRE: begin
        cmd      = CMD_PRE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RP - 2);
        state_d  = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (tmr_done) begin
        resp_set = 1'b1;
        state_d  = ST_IDLE;
      end
      ST_REF_WAIT: if (tmr_done) state_d = ST_IDLE;
      ST_SELF_REF: if (sr_exit_i) begin
        cmd      = CMD_SRX;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_XS - 2);
        state_d  = ST_SRX_WAIT;
      end
      ST_SRX_WAIT: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      ref_pend_q <= 1'b0;
      resp_q     <= 1'b0;
      resp_wr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      resp_q  <= resp_set;
      if (resp_set) resp_wr_q <= wr_q;
      if (accept) begin
        wr_q   <= req_write_i;
        addr_q <= req_addr_i;
        data_q <= req_wdata_i;
      end
      // self-refresh covers refresh internally: drop requests there
      if (ref_clr)
        ref_pend_q <= 1'b0;
      else if (state_q == ST_SELF_REF || state_q == ST_SRX_WAIT)
        ref_pend_q <= 1'b0;
      else if (ref_req_i)
        ref_pend_q <= 1'b1;
    end
  end

  bank_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  bank_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (store_we),
    .re_i   (store_re),
    .addr_i (addr_q),
    .wdata_i(data_q),
    .rdata_o(resp_rdata_o)
  );

  assign req_ready_o  = ready;
  assign resp_valid_o = resp_q;
  assign resp_write_o = resp_wr_q;
  assign cmd_o        = cmd;

endmodule

// File: rtl/dram_bank_sched_chk.sv
module dram_bank_sched_chk
  import dram_bank_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 2,
  parameter int T_RFC = 6,
  parameter int T_XS  = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       resp_valid_o,
  input logic [2:0] cmd_o
);

  localparam logic [7:0] RCD8 = 8'(T_RCD);
  localparam logic [7:0] RP8  = 8'(T_RP);
  localparam logic [7:0] RFC8 = 8'(T_RFC);
  localparam logic [7:0] XS8  = 8'(T_XS);

  logic [7:0] since_act, since_pre, since_ref, since_srx;
  logic       outstanding, in_sr;
  logic       col_cmd, busy_cmd, accept;

  assign col_cmd  = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);
  assign busy_cmd = (cmd_o == CMD_ACT) || (cmd_o == CMD_REF) || (cmd_o == CMD_SRE);
  assign accept   = req_valid_i && req_ready_o;

  function automatic logic [7:0] bump(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act   <= 8'hFF;
      since_pre   <= 8'hFF;
      since_ref   <= 8'hFF;
      since_srx   <= 8'hFF;
      outstanding <= 1'b0;
      in_sr       <= 1'b0;
    end else begin
      since_act <= (cmd_o == CMD_ACT) ? 8'd1 : bump(since_act);
      since_pre <= (cmd_o == CMD_PRE) ? 8'd1 : bump(since_pre);
      since_ref <= (cmd_o == CMD_REF) ? 8'd1 : bump(since_ref);
      since_srx <= (cmd_o == CMD_SRX) ? 8'd1 : bump(since_srx);
      if (accept)            outstanding <= 1'b1;
      else if (resp_valid_o) outstanding <= 1'b0;
      if (cmd_o == CMD_SRE)      in_sr <= 1'b1;
      else if (cmd_o == CMD_SRX) in_sr <= 1'b0;
    end
  end

  assert_pre_after_col_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cmd |=> (cmd_o == CMD_PRE));

  assert_act_to_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cmd |-> (since_act == RCD8));

  assert_precharge_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cmd |-> (since_pre >= RP8));

  assert_refresh_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cmd |-> (since_ref >= RFC8));

  assert_no_accept_in_sr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sr |-> !req_ready_o);

  assert_exit_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cmd |-> (since_srx >= XS8));

  assert_accept_is_act_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (cmd_o == CMD_ACT));

  assert_resp_matches_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> outstanding);

  assert_single_outstanding_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (!outstanding || resp_valid_o));

endmodule

bind dram_bank_sched dram_bank_sched_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_XS(T_XS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .resp_valid_o(resp_valid_o),
  .cmd_o       (cmd_o)
);

// File: tb/dram_bank_sched_bench.sv
module dram_bank_sched_bench;
  import dram_bank_pkg::*;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int T_RCD  = 3;
  localparam int T_RP   = 2;
  localparam int T_RFC  = 6;
  localparam int T_XS   = 4;
  localparam int N_VEC  = 8;

  // {write, addr[3:0], wdata[15:0], expected rdata[15:0]}
  localparam logic [36:0] VEC [N_VEC] = '{
    {1'b1, 4'h0, 16'h1234, 16'h0000},
    {1'b1, 4'h5, 16'hBEEF, 16'h0000},
    {1'b1, 4'hF, 16'h0F0F, 16'h0000},
    {1'b0, 4'h5, 16'h0000, 16'hBEEF},
    {1'b0, 4'h0, 16'h0000, 16'h1234},
    {1'b1, 4'h5, 16'hCAFE, 16'h0000},
    {1'b0, 4'h5, 16'h0000, 16'hCAFE},
    {1'b0, 4'hF, 16'h0000, 16'h0F0F}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic              req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic              resp_valid_o;
  logic              resp_write_o;
  logic [DATA_W-1:0] resp_rdata_o;
  logic              ref_req_i = 1'b0;
  logic              sr_enter_i = 1'b0;
  logic              sr_exit_i = 1'b0;
  logic [2:0]        cmd_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk_i = ~clk_i;

  dram_bank_sched #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_XS(T_XS)
  ) u_dram_bank_sched (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  // Runs one access from the request cycle to its response cycle.
  task automatic do_access(input bit w, input logic [3:0] a, input logic [15:0] d,
                           input logic [15:0] exp, input bit inject_ref);
    localparam int LAST = T_RCD + 1 + T_RP;
    req_valid_i = 1'b1;
    req_write_i = w;
    req_addr_i  = a;
    req_wdata_i = d;
    #1;
    while (!req_ready_o) step();
    chk(cmd_o == CMD_ACT, "R1", "act on accept", cmd_o, CMD_ACT);
    for (int k = 1; k <= LAST; k++) begin
      step();
      if (k == 1) begin
        req_valid_i = 1'b0;
        ref_req_i   = inject_ref;
      end
      if (k == 2) ref_req_i = 1'b0;
      #1;
      if (k < T_RCD) begin
        chk(cmd_o == CMD_NOP, "R2", "nop before column", cmd_o, CMD_NOP);
        chk(!req_ready_o, "R9", "busy during access", req_ready_o, 0);
      end else if (k == T_RCD) begin
        chk(cmd_o == (w ? CMD_WR : CMD_RD), "R2", "column at tRCD", cmd_o,
            w ? CMD_WR : CMD_RD);
      end else if (k == T_RCD + 1) begin
        chk(cmd_o == CMD_PRE, "R1", "precharge after column", cmd_o, CMD_PRE);
      end else if (k < LAST) begin
        chk(cmd_o == CMD_NOP && !req_ready_o, "R3", "tRP hold", cmd_o, CMD_NOP);
      end
      if (k == LAST) begin
        chk(resp_valid_o, "R9", "response pulse", resp_valid_o, 1);
        chk(resp_write_o == w, "R9", "response kind", resp_write_o, w);
        if (!w) chk(resp_rdata_o == exp, "R8", "read data", resp_rdata_o, exp);
      end else begin
        chk(!resp_valid_o, "R9", "no early response", resp_valid_o, 0);
      end
    end
  endtask

  initial begin
    #45;
    #1;
    chk(req_ready_o && !resp_valid_o && cmd_o == CMD_NOP, "R10", "reset state",
        {req_ready_o, resp_valid_o, cmd_o}, 5'b10000);
    rst_ni = 1'b1;
    step();
    chk(req_ready_o && !resp_valid_o && cmd_o == CMD_NOP, "R10", "idle after reset",
        {req_ready_o, resp_valid_o, cmd_o}, 5'b10000);

    // table walk, back to back (R1 R2 R3 R8 R9)
    for (int i = 0; i < N_VEC; i++) begin
      do_access(VEC[i][36], VEC[i][35:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
    end
    step();
    chk(!resp_valid_o, "R9", "single response pulse", resp_valid_o, 0);

    // R4: refresh from idle
    ref_req_i = 1'b1;
    #1;
    chk(cmd_o == CMD_REF && !req_ready_o, "R4", "refresh in idle", cmd_o, CMD_REF);
    for (int k = 1; k < T_RFC; k++) begin
      step();
      ref_req_i = 1'b0;
      chk(!req_ready_o && cmd_o == CMD_NOP, "R4", "tRFC busy", req_ready_o, 0);
    end
    step();
    chk(req_ready_o, "R4", "ready after tRFC", req_ready_o, 1);

    // R5: refresh raised mid-access with next request waiting
    do_access(1'b1, 4'h3, 16'h5A5A, 16'h0, 1'b1);
    req_valid_i = 1'b1;
    req_write_i = 1'b0;
    req_addr_i  = 4'h3;
    #1;
    chk(cmd_o == CMD_REF, "R5", "deferred refresh wins", cmd_o, CMD_REF);
    chk(!req_ready_o, "R5", "request held off", req_ready_o, 0);
    for (int k = 1; k < T_RFC; k++) begin
      step();
      chk(cmd_o == CMD_NOP, "R5", "no act during tRFC", cmd_o, CMD_NOP);
    end
    step();
    chk(req_ready_o && cmd_o == CMD_ACT, "R5", "act after deferred refresh", cmd_o, CMD_ACT);
    do_access(1'b0, 4'h3, 16'h0, 16'h5A5A, 1'b0);

    // R6 R7 R11: self-refresh beats a request; refresh during it dropped
    step();
    sr_enter_i  = 1'b1;
    req_valid_i = 1'b1;
    req_write_i = 1'b0;
    req_addr_i  = 4'h0;
    #1;
    chk(cmd_o == CMD_SRE && !req_ready_o, "R11", "self-refresh before request",
        cmd_o, CMD_SRE);
    for (int k = 0; k < 4; k++) begin
      step();
      sr_enter_i = 1'b0;
      ref_req_i  = (k == 1);
      #1;
      chk(!req_ready_o && cmd_o == CMD_NOP, "R6", "blocked in self-refresh", req_ready_o, 0);
    end
    step();
    ref_req_i = 1'b0;
    sr_exit_i = 1'b1;
    #1;
    chk(cmd_o == CMD_SRX, "R6", "exit command", cmd_o, CMD_SRX);
    for (int k = 1; k < T_XS; k++) begin
      step();
      sr_exit_i = 1'b0;
      chk(!req_ready_o, "R6", "exit delay", req_ready_o, 0);
    end
    step();
    chk(cmd_o == CMD_ACT, "R7", "no refresh after exit", cmd_o, CMD_ACT);
    do_access(1'b0, 4'h0, 16'h0, 16'h1234, 1'b0);

    // R11: refresh beats self-refresh entry
    step();
    ref_req_i  = 1'b1;
    sr_enter_i = 1'b1;
    #1;
    chk(cmd_o == CMD_REF, "R11", "refresh before self-refresh", cmd_o, CMD_REF);
    for (int k = 1; k < T_RFC; k++) begin
      step();
      ref_req_i = 1'b0;
    end
    step();
    chk(cmd_o == CMD_SRE, "R11", "self-refresh after refresh", cmd_o, CMD_SRE);
    step();
    sr_enter_i = 1'b0;
    sr_exit_i  = 1'b1;
    #1;
    chk(cmd_o == CMD_SRX, "R6", "exit second time", cmd_o, CMD_SRX);
    for (int k = 1; k < T_XS; k++) begin
      step();
      sr_exit_i = 1'b0;
    end
    step();
    chk(req_ready_o, "R6", "ready after tXS", req_ready_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule